// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock

This block is a memory-mapped real-time clock that keeps a 32-bit count of seconds. A prescaler divides the system clock down to a one-cycle tick once per second, and each tick advances an internal counter while the run bit is set. Software never reads the raw counter. Reads of the time word return the internal counter plus a software-written offset, so software sets the clock by writing the offset and then writing the control word, which zeroes the counter.

A compare word is checked against the same sum after every increment. A hit sets a sticky raw status flag. A mask bit gates that flag onto a single level-sensitive interrupt line, and a write-one-to-clear word removes the flag. The block sits on a simple single-cycle 32-bit register bus inside a 4 KB window. The top eight words of the window hold fixed identification bytes.

Top module: `sec_rtc`

## Requirements
- R1: Byte offsets are: time 0x00, compare 0x04, offset 0x08, control 0x0C, mask 0x10, raw status 0x14, masked status 0x18, clear 0x1C. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Compare and offset read back the last value written.
- R2: A read of 0x00 returns the internal counter plus the offset word, modulo 2^32.
- R3: Every write to 0x0C zeroes the internal counter, whatever the written value. This includes a write that leaves the run bit unchanged.
- R4: The counter advances by one every CLK_HZ clocks while control bit 0 is 1. It holds while that bit is 0.
- R5: When the run bit goes from 0 to 1, the one-second interval starts over. The first increment lands exactly CLK_HZ clocks after the enabling write.
- R6: If, after an increment, counter plus offset equals the compare word, raw status (bit 0 of 0x14) becomes 1. It stays 1 until it is cleared.
- R7: Mask bit 0 at 0x10 is readable and writable. Masked status (bit 0 of 0x18) and `irq` are 1 exactly when raw status is 1 and the mask bit is 0.
- R8: Writing a word with bit 0 set to 0x1C clears raw status. If a matching increment happens on the same edge, raw status is set instead.
- R9: Writes to 0x00, 0x14 and 0x18 change nothing. Offset 0x1C reads as zero. Unmapped offsets read as zero.
- R10: The words at 0xFE0, 0xFE4, 0xFE8, 0xFEC read 0x31, 0x10, 0x04, 0x00. The words at 0xFF0, 0xFF4, 0xFF8, 0xFFC read 0x0D, 0xF0, 0x05, 0xB1.
- R11: A read of 0x0C returns the run bit in bit 0, with all other bits zero.
- R12: After reset, the counter, compare, offset, run, mask and raw status are all zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a read access |
| irq | output | 1 | Level interrupt: raw status and not masked |

## Verification
The bench builds the block with CLK_HZ set to 8, so one second lasts eight clocks. With that setting, multi-second runs, compare hits and the restart of the interval after a stop all fit into a few hundred cycles. The short second also lets the bench place a clear write on the exact edge of a matching increment by counting clocks. Offset values close to 2^32 bring the modulo wrap of the time sum into reach within three seconds.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int WIDX_W = ADDR_W - 2;

    // word indices (byte offset / 4)
    localparam logic [WIDX_W-1:0] W_TIME  = 10'h000;
    localparam logic [WIDX_W-1:0] W_CMP   = 10'h001;
    localparam logic [WIDX_W-1:0] W_OFS   = 10'h002;
    localparam logic [WIDX_W-1:0] W_CTRL  = 10'h003;
    localparam logic [WIDX_W-1:0] W_MASK  = 10'h004;
    localparam logic [WIDX_W-1:0] W_RAW   = 10'h005;
    localparam logic [WIDX_W-1:0] W_MSTAT = 10'h006;
    localparam logic [WIDX_W-1:0] W_CLR   = 10'h007;

    // identification block: upper bits of the word index
    localparam logic [WIDX_W-4:0] ID_HI = 7'h7F;
    localparam int ID_WORDS = 8;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] ofs;
        logic              run;
        logic              mask;
        logic              raw;
    } rtc_state_t;

    function automatic logic [7:0] id_byte(input int unsigned idx);
        case (idx)
            0: id_byte = 8'h31;
            1: id_byte = 8'h10;
            2: id_byte = 8'h04;
            3: id_byte = 8'h00;
            4: id_byte = 8'h0D;
            5: id_byte = 8'hF0;
            6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] TERM = PW'(CLK_HZ - 1);

    logic [PW-1:0] div_d, div_q;

    // While stopped the divider sits at zero, so a new start begins a full interval.
    always_comb begin
        tick  = run && (div_q == TERM);
        div_d = div_q;
        if (!run || tick) div_d = '0;
        else              div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
    import sec_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output rtc_state_t        st,
    output logic              ctrl_wr,
    output logic              clr_wr
);
    rtc_state_t st_d, st_q;
    logic [DATA_W-1:0] cnt_inc;
    logic hit;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + 1'b1;
        ctrl_wr = wr_en && (widx == W_CTRL);
        clr_wr  = wr_en && (widx == W_CLR) && wdata[0];
        hit     = tick && !ctrl_wr && ((cnt_inc + st_q.ofs) == st_q.cmp);

        if (tick) st_d.cnt = cnt_inc;

        if (wr_en) begin
            case (widx)
                W_CMP:  st_d.cmp  = wdata;
                W_OFS:  st_d.ofs  = wdata;
                W_CTRL: begin
                    st_d.cnt = '0;
                    st_d.run = wdata[0];
                end
                W_MASK: st_d.mask = wdata[0];
                W_CLR:  if (wdata[0]) st_d.raw = 1'b0;
                default: ;
            endcase
        end

        // a hit on the same edge as a clear wins
        if (hit) st_d.raw = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/sec_rtc_rdmux.sv
module sec_rtc_rdmux
    import sec_rtc_pkg::*;
(
    input  logic              rd_en,
    input  logic [WIDX_W-1:0] widx,
    input  rtc_state_t        st,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] id_word [ID_WORDS];

    for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
        assign id_word[g] = DATA_W'(id_byte(g));
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (widx[WIDX_W-1:3] == ID_HI) begin
                rdata = id_word[widx[2:0]];
            end else begin
                case (widx)
                    W_TIME:  rdata = st.cnt + st.ofs;
                    W_CMP:   rdata = st.cmp;
                    W_OFS:   rdata = st.ofs;
                    W_CTRL:  rdata = DATA_W'(st.run);
                    W_MASK:  rdata = DATA_W'(st.mask);
                    W_RAW:   rdata = DATA_W'(st.raw);
                    W_MSTAT: rdata = DATA_W'(st.raw & ~st.mask);
                    default: rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [WIDX_W-1:0] widx;
    logic [1:0]        unused_lsb;
    rtc_state_t        st;
    logic              tick, ctrl_wr, clr_wr;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = bus_addr[1:0];

    sec_rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(st.run), .tick(tick)
    );

    sec_rtc_core u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_sel && bus_wr), .widx(widx),
        .wdata(bus_wdata), .tick(tick), .st(st), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr)
    );

    sec_rtc_rdmux u_rd (
        .rd_en(bus_sel && !bus_wr), .widx(widx), .st(st), .rdata(bus_rdata)
    );

    assign irq = st.raw && !st.mask;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
    import sec_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ctrl_wr,
    input logic              clr_wr,
    input logic              run,
    input logic              raw,
    input logic [DATA_W-1:0] cnt
);
    p_ctrl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (cnt == '0));

    p_tick_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_wr) |=> (cnt == $past(cnt) + 1'b1));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_wr) |=> $stable(cnt));

    p_no_tick_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    p_raw_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_wr) |=> raw);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !tick) |=> !raw);
endmodule

bind sec_rtc sec_rtc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
    .run(st.run), .raw(st.raw), .cnt(st.cnt)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb_top;
    localparam int HZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sec_rtc #(.CLK_HZ(HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_time(input logic [31:0] ofs, input int secs);
        return ofs + 32'(secs);
    endfunction

    function automatic logic exp_irq(input logic raw, input logic mask);
        return raw && !mask;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, ofs, cmp;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        for (int i = 0; i < 8; i++) begin
            rd(12'(i * 4), v);
            chk("R12 reset", v, 32'h0);
        end
        chk("R12 irq", 32'(irq), 32'h0);

        // R10 identification words
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            case (i)
                0: e = 8'h31; 1: e = 8'h10; 2: e = 8'h04; 3: e = 8'h00;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
            endcase
            rd(12'hFE0 + 12'(i * 4), v);
            chk("R10 id", v, {24'h0, e});
        end

        // R1 / R2 / R11 random register traffic with the clock stopped
        for (int i = 0; i < 40; i++) begin
            logic [31:0] m, c;
            ofs = $urandom; m = $urandom; c = $urandom;
            wr(12'h004, m);
            wr(12'h008, ofs);
            wr(12'h00C, c & 32'hFFFF_FFFE);
            rd(12'h004, v); chk("R1 compare", v, m);
            rd(12'h008, v); chk("R1 offset", v, ofs);
            rd(12'h00C, v); chk("R11 control", v, 32'h0);
            rd(12'h000, v); chk("R2 time", v, exp_time(ofs, 0));
        end

        // R9 unmapped and write-only offsets read zero
        rd(12'h01C, v); chk("R9 clear reads 0", v, 0);
        for (int i = 0; i < 20; i++) begin
            logic [11:0] a;
            a = 12'h020 + 12'(($urandom % 976) * 4);
            rd(a, v); chk("R9 unmapped", v, 0);
        end

        // R4 / R11 / R2 counting, with offset wrap
        ofs = 32'hFFFF_FFFE;
        wr(12'h008, ofs);
        wr(12'h004, 32'h1234_5678);
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, v); chk("R11 run readback", v, 32'h1);
        cyc(3 * HZ);
        rd(12'h000, v); chk("R2 wrap", v, exp_time(ofs, 3));
        chk("R2 wrap value", v, 32'h1);

        // R3 control write while running zeroes counter
        wr(12'h00C, 32'h1);
        rd(12'h000, v); chk("R3 zero", v, exp_time(ofs, 0));

        // R4 stopped counter holds
        wr(12'h00C, 32'h0);
        cyc(5 * HZ);
        rd(12'h000, v); chk("R4 hold", v, exp_time(ofs, 0));

        // R5 restart of interval
        ofs = $urandom;
        wr(12'h008, ofs);
        wr(12'h00C, 32'h1);
        cyc(5);
        wr(12'h00C, 32'h0);
        wr(12'h00C, 32'h1);
        cyc(HZ - 1);
        rd(12'h000, v); chk("R5 before", v, exp_time(ofs, 0));
        cyc(1);
        rd(12'h000, v); chk("R5 first", v, exp_time(ofs, 1));

        // R6 / R7 match and masking
        wr(12'h00C, 32'h0);
        ofs = $urandom;
        cmp = ofs + 32'd3;
        wr(12'h008, ofs);
        wr(12'h004, cmp);
        wr(12'h00C, 32'h1);
        cyc(2 * HZ);
        rd(12'h014, v); chk("R6 no hit yet", v, 0);
        chk("R7 irq low", 32'(irq), 0);
        cyc(HZ);
        rd(12'h014, v); chk("R6 hit", v, 1);
        chk("R7 irq", 32'(irq), 32'(exp_irq(1'b1, 1'b0)));
        rd(12'h018, v); chk("R7 masked", v, 1);
        wr(12'h010, 32'h1);
        rd(12'h010, v); chk("R7 mask rb", v, 1);
        rd(12'h018, v); chk("R7 masked off", v, 0);
        chk("R7 irq masked", 32'(irq), 32'(exp_irq(1'b1, 1'b1)));
        cyc(2 * HZ);
        rd(12'h014, v); chk("R6 sticky", v, 1);

        // R9 writes to read-only words
        wr(12'h000, 32'hDEAD_BEEF);
        wr(12'h014, 32'h0);
        wr(12'h018, 32'h0);
        rd(12'h014, v); chk("R9 raw kept", v, 1);
        wr(12'h00C, 32'h0);
        rd(12'h000, v); chk("R9 time kept", v, exp_time(ofs, 0));

        // R8 clear, with bit 0 clear first (no effect)
        wr(12'h01C, 32'hFFFF_FFFE);
        rd(12'h014, v); chk("R8 bit0 only", v, 1);
        wr(12'h01C, 32'h1);
        rd(12'h014, v); chk("R8 clear", v, 0);
        wr(12'h010, 32'h0);
        chk("R7 irq after clear", 32'(irq), 0);

        // R8 set wins over clear on the same edge
        ofs = $urandom;
        wr(12'h008, ofs);
        wr(12'h004, ofs + 32'd2);
        wr(12'h00C, 32'h1);
        cyc(2 * HZ - 1);
        wr(12'h01C, 32'h1);
        rd(12'h000, v); chk("R8 on tick edge", v, exp_time(ofs, 2));
        rd(12'h014, v); chk("R8 set wins", v, 1);
        wr(12'h01C, 32'h1);
        rd(12'h014, v); chk("R8 clear off tick", v, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule